// File: doc/BRIEF.md
# Prioritizing Interrupt Request Arbiter

This block gathers service requests from a set of peripheral sources, keeps each request pending until it is served, and on every cycle chooses exactly one winner among the pending requests. Each source has a programmable priority level and a group number, and it is marked as either a standard interrupt or an event-transfer request. A peripheral winner is offered to the processor only if the global enable is set and the winner's level is strictly above the level of the code the processor is running.

A standard winner raises a vectored interrupt request that stays up until the processor acknowledges that source by number. An event-transfer winner produces a single-cycle steal request toward a data-move engine. That pulse consumes the pending request, and no acknowledge is needed. Hardware trap inputs and an external non-maskable input are kept in a separate pending bank. They are always served ahead of every peripheral, regardless of the enable and the processor level.

Source numbering used on `ack_id_i`, `irq_id_o` and `xfer_id_o`: peripherals are 0..NSRC-1, the non-maskable input is NSRC, and trap k is NSRC+1+k.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A request sampled high for one clock is held pending until served. The decision is registered, so the outputs reflect it on the second rising edge after the request is sampled and not on the first.
- R2: Among pending peripheral requests, the one with the highest 4-bit level wins.
- R3: On equal levels the higher 2-bit group number wins. On equal level and group the lower source index wins.
- R4: A peripheral winner is accepted only if its level is strictly greater than `cpu_level_i`. An equal or lower level produces no request, and the source stays pending.
- R5: With `glob_ie_i` low, no peripheral request is offered. Such requests stay pending and are offered one edge after the enable returns.
- R6: An accepted standard winner drives `irq_req_o` high with its number on `irq_id_o` and its level on `irq_level_o`, with `irq_sys_o` low. The request stays up while that source remains the accepted winner.
- R7: An accepted event-transfer winner drives `xfer_req_o` high for exactly one cycle with its number on `xfer_id_o`. `irq_req_o` stays low in that cycle, and the pending flag is cleared by the pulse itself.
- R8: `ack_valid_i` with `ack_id_i` clears that source's pending flag. The next winner is presented right after the acknowledge edge, with no cycle in which the acknowledged source is shown again.
- R9: A new request from a source in the same cycle as its acknowledge is kept. The output drops for one cycle and the source is then offered again.
- R10: Trap and non-maskable requests are served ahead of all peripherals and ignore `glob_ie_i` and `cpu_level_i`. They raise `irq_req_o` with `irq_sys_o` high and `irq_level_o` all ones. Traps rank above the non-maskable input, and a lower trap index ranks above a higher one.
- R11: After reset, `irq_req_o`, `xfer_req_o` and all pending flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req_i | input | NSRC | Peripheral request strobes, one per source |
| src_level_i | input | NSRC*LVL_W | Priority level of each source, source i at bits [i*LVL_W +: LVL_W] |
| src_group_i | input | NSRC*GRP_W | Group number of each source, source i at bits [i*GRP_W +: GRP_W] |
| src_xfer_i | input | NSRC | 1 marks the source as an event-transfer request, 0 as standard |
| glob_ie_i | input | 1 | Global enable for peripheral requests |
| cpu_level_i | input | LVL_W | Priority level of the code now running |
| nmi_req_i | input | 1 | Non-maskable request strobe |
| trap_req_i | input | NTRAP | Hardware trap strobes |
| ack_valid_i | input | 1 | Processor acknowledges one source |
| ack_id_i | input | ID_W | Number of the acknowledged source |
| irq_req_o | output | 1 | Vectored interrupt request |
| irq_id_o | output | ID_W | Number of the requesting source |
| irq_level_o | output | LVL_W | Level of the requesting source, all ones for traps and NMI |
| irq_sys_o | output | 1 | Request comes from a trap or the non-maskable input |
| xfer_req_o | output | 1 | One-cycle steal request for a single transfer |
| xfer_id_o | output | ID_W | Source served by the steal request |

## Verification
Several properties are checked on every cycle: no offered peripheral request has a level at or below the previous processor level, none is offered while the enable was low, and any pending trap or non-maskable request pre-empts the output. The same source never steals two cycles running, an acknowledged source does not stay pending, and the tree's winner is at least as high as every pending level. The order of service can only be shown by the bench scenarios that hold a set of requests and acknowledge them one by one. These scenarios cover the group and index tie-breaks, the two-edge latency, a request re-arriving during its own acknowledge, deferred service after the enable or processor level changes, and the trap-over-NMI ordering.

// File: rtl/irq_arb_pkg.sv
// Package: shared decision encoding for the interrupt request arbiter.
// Assumes: used by irq_decide and irq_prio_arbiter only.
package irq_arb_pkg;

    // Kind of decision held in the output register
    typedef enum logic [1:0] {
        DEC_NONE = 2'd0,
        DEC_STD  = 2'd1,
        DEC_XFER = 2'd2
    } dec_kind_e;

endpackage

// File: rtl/irq_pend_bank.sv
// Module: irq_pend_bank
// Keeps one pending flag per request line. A strobe sets the flag. An
// acknowledge whose number matches (BASE + bit index) clears it, and so does
// a consume strobe naming the same number. A set in the same cycle as a
// clear wins. The effective vector hides a flag in the cycle it is being
// acknowledged, so that arbitration moves on at once.
// Assumes: ack and consume numbers are ID_W wide; BASE + N fits in ID_W.
module irq_pend_bank #(
    parameter int N    = 8,
    parameter int ID_W = 4,
    parameter int BASE = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    set_i,
    input  logic            ack_valid_i,
    input  logic [ID_W-1:0] ack_id_i,
    input  logic            take_i,
    input  logic [ID_W-1:0] take_id_i,
    output logic [N-1:0]    eff_o
);

    logic [N-1:0] pend_q;
    logic [N-1:0] ack_hit;
    logic [N-1:0] take_hit;

    for (genvar i = 0; i < N; i++) begin : g_line
        localparam logic [ID_W-1:0] MY_ID = ID_W'(BASE + i);

        // Decode the acknowledge and consume strobes for this line
        always_comb begin
            ack_hit[i]  = ack_valid_i && (ack_id_i == MY_ID);
            take_hit[i] = take_i && (take_id_i == MY_ID);
        end

        // Pending flag: set wins over clear, synchronous reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[i] <= 1'b0;
            else if (set_i[i])
                pend_q[i] <= 1'b1;
            else if (ack_hit[i] || take_hit[i])
                pend_q[i] <= 1'b0;
        end

        // Acknowledged line without a new strobe is gone next cycle
        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_hit[i] && !set_i[i]) |=> !pend_q[i]); // R8

        // A strobe always leaves the line pending
        AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> pend_q[i]); // R9
    end

    // Effective vector: pending lines not being acknowledged this cycle
    always_comb begin
        eff_o = pend_q & ~ack_hit;
    end

endmodule

// File: rtl/irq_prio_tree.sv
// Module: irq_prio_tree
// Combinational comparison tree over the pending peripheral lines. It returns
// the line with the highest level; on equal levels the higher group, on equal
// group the lower index. The tree is padded to a power of two with empty
// leaves. The left subtree always holds the lower indices, so a full tie
// keeps the left side.
// Assumes: N >= 2; clk and rst_n are used only by the checks.
module irq_prio_tree #(
    parameter int N     = 8,
    parameter int LVL_W = 4,
    parameter int GRP_W = 2,
    parameter int IDX_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       eff_i,
    input  logic [N*LVL_W-1:0] level_i,
    input  logic [N*GRP_W-1:0] group_i,
    input  logic [N-1:0]       xfer_i,
    output logic               win_vld_o,
    output logic [IDX_W-1:0]   win_idx_o,
    output logic [LVL_W-1:0]   win_level_o,
    output logic               win_xfer_o
);

    localparam int LEAVES = 1 << $clog2(N);
    localparam int NODES  = 2 * LEAVES - 1;

    typedef struct packed {
        logic             vld;
        logic [LVL_W-1:0] lvl;
        logic [GRP_W-1:0] grp;
        logic             xfer;
        logic [IDX_W-1:0] idx;
    } node_t;

    node_t nodes [NODES];

    // Select the stronger of two candidates, left on a full tie
    function automatic node_t pick(input node_t a, input node_t b);
        logic a_wins;
        if (!a.vld)
            a_wins = 1'b0;
        else if (!b.vld)
            a_wins = 1'b1;
        else if (a.lvl != b.lvl)
            a_wins = (a.lvl > b.lvl);
        else if (a.grp != b.grp)
            a_wins = (a.grp > b.grp);
        else
            a_wins = 1'b1;
        return a_wins ? a : b;
    endfunction

    // Fill the leaves and reduce the tree bottom-up in one process
    always_comb begin
        for (int i = 0; i < LEAVES; i++) begin
            if (i < N) begin
                nodes[LEAVES-1+i].vld  = eff_i[i];
                nodes[LEAVES-1+i].lvl  = level_i[i*LVL_W +: LVL_W];
                nodes[LEAVES-1+i].grp  = group_i[i*GRP_W +: GRP_W];
                nodes[LEAVES-1+i].xfer = xfer_i[i];
                nodes[LEAVES-1+i].idx  = IDX_W'(i);
            end else begin
                nodes[LEAVES-1+i] = '0;
            end
        end
        for (int n = LEAVES - 2; n >= 0; n--) begin
            nodes[n] = pick(nodes[2*n+1], nodes[2*n+2]);
        end
    end

    // Root of the tree drives the outputs
    always_comb begin
        win_vld_o   = nodes[0].vld;
        win_idx_o   = nodes[0].idx;
        win_level_o = nodes[0].lvl;
        win_xfer_o  = nodes[0].xfer;
    end

    // The winner is valid whenever any line is pending
    AST_WIN_ANY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (|eff_i) |-> (win_vld_o && eff_i[win_idx_o])); // R2

    for (genvar i = 0; i < N; i++) begin : g_chk
        // No pending line outranks the chosen one
        AST_WIN_IS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
            eff_i[i] |-> (level_i[i*LVL_W +: LVL_W] <= win_level_o)); // R2
    end

endmodule

// File: rtl/irq_decide.sv
// Module: irq_decide
// Final decision stage. Pending trap or NMI lines pre-empt everything, and
// among them traps rank above NMI, lower trap first. Otherwise the tree's
// winner is accepted if the enable is set and its level beats the processor
// level. The result is registered. An accepted transfer winner also drives
// the consume strobe back to the pending bank in the same cycle.
// Assumes: sys bit 0 is NMI (number NSRC), bit k>0 is trap k-1 (NSRC+k).
module irq_decide
    import irq_arb_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int NSYS  = 3,
    parameter int LVL_W = 4,
    parameter int ID_W  = 4,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glob_ie_i,
    input  logic [LVL_W-1:0] cpu_level_i,
    input  logic [NSYS-1:0]  sys_eff_i,
    input  logic             win_vld_i,
    input  logic [IDX_W-1:0] win_idx_i,
    input  logic [LVL_W-1:0] win_level_i,
    input  logic             win_xfer_i,
    output logic             take_o,
    output logic [ID_W-1:0]  take_id_o,
    output logic             irq_req_o,
    output logic [ID_W-1:0]  irq_id_o,
    output logic [LVL_W-1:0] irq_level_o,
    output logic             irq_sys_o,
    output logic             xfer_req_o,
    output logic [ID_W-1:0]  xfer_id_o
);

    dec_kind_e        kind_d, kind_q;
    logic [ID_W-1:0]  id_d, id_q;
    logic [LVL_W-1:0] lvl_d, lvl_q;
    logic             sys_d, sys_q;
    logic             sys_hit;
    int               sys_sel;
    logic             periph_ok;

    // Pick the strongest system line: traps by index, then NMI
    always_comb begin
        sys_hit = 1'b0;
        sys_sel = 0;
        for (int k = NSYS - 1; k >= 1; k--) begin
            if (sys_eff_i[k]) begin
                sys_hit = 1'b1;
                sys_sel = k;
            end
        end
        if (!sys_hit && sys_eff_i[0]) begin
            sys_hit = 1'b1;
            sys_sel = 0;
        end
    end

    // Accept test for the peripheral winner
    always_comb begin
        periph_ok = win_vld_i && glob_ie_i && (win_level_i > cpu_level_i);
    end

    // Build the next decision and the consume strobe
    always_comb begin
        kind_d    = DEC_NONE;
        id_d      = '0;
        lvl_d     = '0;
        sys_d     = 1'b0;
        take_o    = 1'b0;
        take_id_o = ID_W'(win_idx_i);
        if (sys_hit) begin
            kind_d = DEC_STD;
            id_d   = ID_W'(NSRC + sys_sel);
            lvl_d  = '1;
            sys_d  = 1'b1;
        end else if (periph_ok) begin
            id_d  = ID_W'(win_idx_i);
            lvl_d = win_level_i;
            if (win_xfer_i) begin
                kind_d = DEC_XFER;
                take_o = 1'b1;
            end else begin
                kind_d = DEC_STD;
            end
        end
    end

    // Decision register, synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= DEC_NONE;
            id_q   <= '0;
            lvl_q  <= '0;
            sys_q  <= 1'b0;
        end else begin
            kind_q <= kind_d;
            id_q   <= id_d;
            lvl_q  <= lvl_d;
            sys_q  <= sys_d;
        end
    end

    // Map the registered decision to the handshake outputs
    always_comb begin
        irq_req_o   = (kind_q == DEC_STD);
        xfer_req_o  = (kind_q == DEC_XFER);
        irq_id_o    = id_q;
        xfer_id_o   = id_q;
        irq_level_o = lvl_q;
        irq_sys_o   = sys_q;
    end

    AST_PERIPH_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (irq_req_o || xfer_req_o) && !irq_sys_o)
            |-> (irq_level_o > $past(cpu_level_i))); // R4

    AST_PERIPH_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (irq_req_o || xfer_req_o) && !irq_sys_o)
            |-> $past(glob_ie_i)); // R5

    AST_SYS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(|sys_eff_i))
            |-> (irq_req_o && irq_sys_o && (irq_level_o == '1))); // R10

    AST_XFER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |=> !(xfer_req_o && (xfer_id_o == $past(xfer_id_o)))); // R7

endmodule

// File: rtl/irq_prio_arbiter.sv
// Module: irq_prio_arbiter (top)
// Interrupt request arbiter. It has a pending bank for peripheral lines, a
// second pending bank for trap and NMI lines, a priority tree over the
// peripheral lines, and a registered decision stage. It serves standard
// interrupts through irq_req_o with acknowledge by number, and transfer
// requests through a one-cycle xfer_req_o pulse.
// Assumes: numbering 0..NSRC-1 peripherals, NSRC NMI, NSRC+1+k trap k.
module irq_prio_arbiter #(
    parameter int NSRC  = 8,
    parameter int NTRAP = 2,
    parameter int LVL_W = 4,
    parameter int GRP_W = 2,
    parameter int ID_W  = $clog2(NSRC + NTRAP + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       src_req_i,
    input  logic [NSRC*LVL_W-1:0] src_level_i,
    input  logic [NSRC*GRP_W-1:0] src_group_i,
    input  logic [NSRC-1:0]       src_xfer_i,
    input  logic                  glob_ie_i,
    input  logic [LVL_W-1:0]      cpu_level_i,
    input  logic                  nmi_req_i,
    input  logic [NTRAP-1:0]      trap_req_i,
    input  logic                  ack_valid_i,
    input  logic [ID_W-1:0]       ack_id_i,
    output logic                  irq_req_o,
    output logic [ID_W-1:0]       irq_id_o,
    output logic [LVL_W-1:0]      irq_level_o,
    output logic                  irq_sys_o,
    output logic                  xfer_req_o,
    output logic [ID_W-1:0]       xfer_id_o
);

    localparam int NSYS  = NTRAP + 1;
    localparam int IDX_W = $clog2(NSRC);

    logic [NSRC-1:0]  src_eff;
    logic [NSYS-1:0]  sys_eff;
    logic [NSYS-1:0]  sys_set;
    logic             win_vld;
    logic [IDX_W-1:0] win_idx;
    logic [LVL_W-1:0] win_level;
    logic             win_xfer;
    logic             take;
    logic [ID_W-1:0]  take_id;

    // System line order: bit 0 NMI, bits above are the traps
    always_comb begin
        sys_set = {trap_req_i, nmi_req_i};
    end

    irq_pend_bank #(.N(NSRC), .ID_W(ID_W), .BASE(0)) u_src_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (src_req_i),
        .ack_valid_i (ack_valid_i),
        .ack_id_i    (ack_id_i),
        .take_i      (take),
        .take_id_i   (take_id),
        .eff_o       (src_eff)
    );

    irq_pend_bank #(.N(NSYS), .ID_W(ID_W), .BASE(NSRC)) u_sys_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (sys_set),
        .ack_valid_i (ack_valid_i),
        .ack_id_i    (ack_id_i),
        .take_i      (1'b0),
        .take_id_i   ('0),
        .eff_o       (sys_eff)
    );

    irq_prio_tree #(.N(NSRC), .LVL_W(LVL_W), .GRP_W(GRP_W), .IDX_W(IDX_W)) u_tree (
        .clk         (clk),
        .rst_n       (rst_n),
        .eff_i       (src_eff),
        .level_i     (src_level_i),
        .group_i     (src_group_i),
        .xfer_i      (src_xfer_i),
        .win_vld_o   (win_vld),
        .win_idx_o   (win_idx),
        .win_level_o (win_level),
        .win_xfer_o  (win_xfer)
    );

    irq_decide #(.NSRC(NSRC), .NSYS(NSYS), .LVL_W(LVL_W), .ID_W(ID_W), .IDX_W(IDX_W)) u_decide (
        .clk         (clk),
        .rst_n       (rst_n),
        .glob_ie_i   (glob_ie_i),
        .cpu_level_i (cpu_level_i),
        .sys_eff_i   (sys_eff),
        .win_vld_i   (win_vld),
        .win_idx_i   (win_idx),
        .win_level_i (win_level),
        .win_xfer_i  (win_xfer),
        .take_o      (take),
        .take_id_o   (take_id),
        .irq_req_o   (irq_req_o),
        .irq_id_o    (irq_id_o),
        .irq_level_o (irq_level_o),
        .irq_sys_o   (irq_sys_o),
        .xfer_req_o  (xfer_req_o),
        .xfer_id_o   (xfer_id_o)
    );

    // Standard and transfer outputs never share a cycle
    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_req_o && xfer_req_o)); // R7

endmodule

// File: tb/sim_irq_prio_arbiter.sv
// Scoreboard bench: the driver pushes the expected service events, and a
// monitor pops them when the design presents a new request or a steal pulse.
module sim_irq_prio_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_req = '0;
    logic [31:0] src_level = '0;
    logic [15:0] src_group = '0;
    logic [7:0]  src_xfer = '0;
    logic        glob_ie = 1'b0;
    logic [3:0]  cpu_level = '0;
    logic        nmi_req = 1'b0;
    logic [1:0]  trap_req = '0;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_id = '0;
    logic        irq_req;
    logic [3:0]  irq_id;
    logic [3:0]  irq_level;
    logic        irq_sys;
    logic        xfer_req;
    logic [3:0]  xfer_id;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .src_level_i(src_level),
        .src_group_i(src_group), .src_xfer_i(src_xfer), .glob_ie_i(glob_ie),
        .cpu_level_i(cpu_level), .nmi_req_i(nmi_req), .trap_req_i(trap_req),
        .ack_valid_i(ack_valid), .ack_id_i(ack_id), .irq_req_o(irq_req),
        .irq_id_o(irq_id), .irq_level_o(irq_level), .irq_sys_o(irq_sys),
        .xfer_req_o(xfer_req), .xfer_id_o(xfer_id)
    );

    typedef struct {
        bit       is_x;
        int       id;
        string    tag;
    } ev_t;

    ev_t exp_q[$];
    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    bit  prev_irq = 1'b0;
    int  prev_id = 0;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_ev(bit is_x, int id, string tag);
        ev_t e;
        e.is_x = is_x; e.id = id; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic got(bit is_x, int id);
        ev_t e;
        n_cmp++;
        if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected event: actual kind %0d id %0d expected none", is_x, id);
        end else begin
            e = exp_q.pop_front();
            if (e.is_x != is_x || e.id != id) begin
                n_bad++;
                $display("FAIL %s: actual kind %0d id %0d expected kind %0d id %0d",
                         e.tag, is_x, id, e.is_x, e.id);
            end
        end
    endtask

    // Monitor: new request presentation or steal pulse
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (xfer_req) got(1'b1, int'(xfer_id));
            if (irq_req && (!prev_irq || int'(irq_id) != prev_id)) got(1'b0, int'(irq_id));
            prev_irq = irq_req;
            prev_id  = int'(irq_id);
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(logic [7:0] s, logic [1:0] t, logic n);
        src_req = s; trap_req = t; nmi_req = n;
        tick();
        src_req = '0; trap_req = '0; nmi_req = 1'b0;
    endtask

    task automatic ack(int id);
        ack_valid = 1'b1; ack_id = 4'(id);
        tick();
        ack_valid = 1'b0;
    endtask

    task automatic cfg(int i, int lvl, int grp, bit x);
        src_level[i*4 +: 4] = 4'(lvl);
        src_group[i*2 +: 2] = 2'(grp);
        src_xfer[i] = x;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        cfg(0, 3, 0, 0); cfg(1, 5, 1, 0); cfg(2, 5, 2, 0); cfg(3, 5, 2, 0);
        cfg(4, 7, 0, 1); cfg(5, 2, 0, 1); cfg(6, 9, 0, 0); cfg(7, 0, 0, 0);
        @(negedge clk);
        repeat (4) tick();
        rst_n = 1'b1;
        glob_ie = 1'b1;
        tick();
        chk("R11 reset irq_req", int'(irq_req), 0);
        chk("R11 reset xfer_req", int'(xfer_req), 0);
        tick();
        chk("R11 nothing pending after reset", int'(irq_req), 0);

        // R1/R6: single request, two-edge latency
        expect_ev(0, 0, "R6 standard request id");
        pulse(8'h01, 2'b00, 1'b0);
        chk("R1 not yet after first edge", int'(irq_req), 0);
        tick();
        chk("R1 request after second edge", int'(irq_req), 1);
        chk("R6 irq_id", int'(irq_id), 0);
        chk("R6 irq_level", int'(irq_level), 3);
        chk("R6 irq_sys low", int'(irq_sys), 0);
        tick();
        chk("R6 held until ack", int'(irq_req), 1);
        ack(0);
        chk("R8 cleared by ack", int'(irq_req), 0);

        // R3: level tie, group then index
        expect_ev(0, 2, "R3 higher group then lower index");
        expect_ev(0, 3, "R8 next winner after ack");
        expect_ev(0, 1, "R3 lower group last");
        pulse(8'h0E, 2'b00, 1'b0);
        tick();
        chk("R3 winner id", int'(irq_id), 2);
        ack(2);
        chk("R8 next shown at once", int'(irq_id), 3);
        chk("R8 still requesting", int'(irq_req), 1);
        ack(3);
        chk("R3 last one", int'(irq_id), 1);
        ack(1);
        chk("R8 all served", int'(irq_req), 0);

        // R4: strictly greater than processor level
        cpu_level = 4'd5;
        pulse(8'h02, 2'b00, 1'b0);
        tick();
        chk("R4 equal level refused", int'(irq_req), 0);
        expect_ev(0, 1, "R4 accepted when level drops");
        cpu_level = 4'd4;
        tick();
        chk("R4 accepted above level", int'(irq_req), 1);
        ack(1);
        cpu_level = 4'd0;

        // R5 and R10: enable masks peripherals, not NMI
        glob_ie = 1'b0;
        pulse(8'h40, 2'b00, 1'b0);
        tick();
        chk("R5 masked by enable", int'(irq_req), 0);
        expect_ev(0, 8, "R10 NMI ignores enable");
        pulse(8'h00, 2'b00, 1'b1);
        tick();
        chk("R10 NMI sys flag", int'(irq_sys), 1);
        chk("R10 NMI level all ones", int'(irq_level), 15);
        ack(8);
        chk("R5 still masked", int'(irq_req), 0);
        expect_ev(0, 6, "R5 offered after enable");
        glob_ie = 1'b1;
        tick();
        chk("R5 offered after enable", int'(irq_id), 6);
        ack(6);

        // R7: event transfer pulse
        expect_ev(1, 4, "R7 steal pulse id");
        pulse(8'h10, 2'b00, 1'b0);
        tick();
        chk("R7 xfer_req high", int'(xfer_req), 1);
        chk("R7 no irq with xfer", int'(irq_req), 0);
        tick();
        chk("R7 single cycle", int'(xfer_req), 0);
        chk("R7 consumed without ack", int'(irq_req), 0);

        // R2/R7: transfer outranks standard, then standard follows
        expect_ev(1, 4, "R2 higher level transfer first");
        expect_ev(0, 0, "R2 lower standard next");
        pulse(8'h11, 2'b00, 1'b0);
        tick();
        chk("R2 transfer first", int'(xfer_req), 1);
        tick();
        chk("R2 standard next", int'(irq_id), 0);
        chk("R2 standard request", int'(irq_req), 1);

        // R9: new request in the acknowledge cycle is kept
        expect_ev(0, 0, "R9 re-offered");
        src_req = 8'h01;
        ack(0);
        src_req = '0;
        chk("R9 drops for one cycle", int'(irq_req), 0);
        tick();
        chk("R9 offered again", int'(irq_req), 1);
        ack(0);

        // R10: trap above NMI, both above processor level
        cpu_level = 4'd15;
        expect_ev(0, 10, "R10 trap first");
        expect_ev(0, 8, "R10 NMI after trap");
        pulse(8'h40, 2'b10, 1'b1);
        tick();
        chk("R10 trap id", int'(irq_id), 10);
        ack(10);
        chk("R10 NMI next", int'(irq_id), 8);
        ack(8);
        chk("R4 peripheral below level", int'(irq_req), 0);
        expect_ev(0, 6, "R4 peripheral after level drop");
        cpu_level = 4'd0;
        tick();
        chk("R4 peripheral served", int'(irq_id), 6);
        ack(6);
        tick();

        done = 1'b1;
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R6 missing events: actual %0d left expected 0", exp_q.size());
        end
        summary();
        $finish;
    end

endmodule